// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors signal each other through one-bit "channel occupied" flags, up to sixteen channels in each direction. A sender raises a flag on a channel to say that a message is waiting for its peer. The receiver drops that flag once it has consumed the message, and the sender reads the dropped flag as "channel free". Payload data lives elsewhere, in shared memory. The block carries only the handshake.

Each processor sees its own bank of four registers: control, mask, set/clear and status. The two banks are mirrors of each other, so the same software runs on either side. The receive interrupt of a processor follows the flags raised by its peer. The transmit interrupt follows the inverse of the processor's own flags. A shared configuration word reports the channel count, and a version word reports the revision. Access goes through a single-cycle bus with byte addresses. Read data is registered.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After a synchronous reset, all occupied flags are clear. Every implemented mask bit reads 1. Both enable bits of each bank read 0. All four interrupt outputs are 0.
- R2: Bank p occupies byte addresses 0x10*p to 0x10*p+0xC. The control register is at +0x0, the mask at +0x4, set/clear at +0x8 and status at +0xC. In the control register, bit 0 is the receive interrupt enable and bit 16 is the transmit interrupt enable. All other control bits read 0. The two banks are independent.
- R3: Writing 1 to bit 16+n of a bank's set/clear register raises that processor's own flag on channel n. A bank's status register returns the flags raised by that processor in bits [15:0] and 0 in the upper bits.
- R4: Writing 1 to bit n of a bank's set/clear register drops the flag on channel n that the peer raised. Zero bits in the written value change nothing. The set/clear register always reads 0.
- R5: The receive interrupt of a processor is 1 when its receive enable is 1 and at least one implemented channel has both of these: a flag raised by the peer, and a receive mask bit (mask bit n) of 0.
- R6: The transmit interrupt of a processor is 1 when its transmit enable is 1 and at least one implemented channel has both of these: its own flag clear, and a transmit mask bit (mask bit 16+n) of 0.
- R7: The mask register holds the receive masks in bits [15:0] and the transmit masks in bits [31:16]. A 1 means masked. The register reads back what was written.
- R8: Address 0x3F0 returns the channel count NUM_CH in bits [7:0]. Address 0x3F4 returns VER_MINOR in bits [3:0] and VER_MAJOR in bits [7:4]. Both are read-only.
- R9: For channels n at or above NUM_CH, the flag bits and mask bits read 0 and ignore writes, and these channels never raise an interrupt.
- R10: The interrupt outputs are registered. They take their new value one clock after the register write that changes their inputs takes effect.
- R11: Reads from addresses that map to no register return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 10 | Byte address of the access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the address of the previous cycle |
| rx_irq | output | 2 | Receive interrupt, one bit per processor |
| tx_irq | output | 2 | Transmit interrupt, one bit per processor |

## Verification
The bench is built with twelve channels, so that channels 12 to 15 are unimplemented.

- **Mirrored banks.** Set/clear values go through both banks. This shows that a flag raised by one side appears only in that side's status, and that only the peer can drop it. A write of all zeros and a write to unimplemented channels must leave the status unchanged.
- **Interrupt gating.** Each interrupt is driven first with its enable off, then with the enable on but the channel masked, then with the channel unmasked. This separates the effect of the enable from the effect of the mask.
- **Interrupt polarity.** A flag is raised and then dropped. The receive interrupt must track the flag and the transmit interrupt must track its inverse.
- **Unimplemented channels.** A transmit enable with all implemented channels masked must stay quiet. This shows that the flags of unimplemented channels, which read as clear, are not counted as free channels.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NPROC   = 2;
  localparam int MAXCH   = 16;
  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 32;

  // register select inside one bank (addr[3:2])
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_SETCLR = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  localparam logic [ADDR_W-1:0] CFG_ADDR = 10'h3F0;
  localparam logic [ADDR_W-1:0] VER_ADDR = 10'h3F4;

  // control register bit positions
  localparam int RXEN_BIT = 0;
  localparam int TXEN_BIT = 16;
endpackage

// File: rtl/mbox_bank.sv
// Control and mask state for one processor, plus set/clear decode.
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hit,
  input  reg_sel_e            sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic                rx_en,
  output logic                tx_en,
  output logic [MAXCH-1:0]    rx_mask,
  output logic [MAXCH-1:0]    tx_mask,
  output logic [MAXCH-1:0]    set_req,
  output logic [MAXCH-1:0]    clr_req
);
  localparam logic [MAXCH-1:0] CHM = MAXCH'((32'd1 << NUM_CH) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
      rx_mask <= CHM;
      tx_mask <= CHM;
    end else if (hit) begin
      if (sel == SEL_CTRL) begin
        rx_en <= wdata[RXEN_BIT];
        tx_en <= wdata[TXEN_BIT];
      end
      if (sel == SEL_MASK) begin
        rx_mask <= wdata[MAXCH-1:0] & CHM;
        tx_mask <= wdata[DATA_W-1:MAXCH] & CHM;
      end
    end
  end

  always_comb begin
    set_req = '0;
    clr_req = '0;
    if (hit && sel == SEL_SETCLR) begin
      set_req = wdata[DATA_W-1:MAXCH] & CHM;
      clr_req = wdata[MAXCH-1:0] & CHM;
    end
  end
endmodule

// File: rtl/mbox_flags.sv
// Occupied flags: flag[p] is raised by processor p and dropped by its peer.
module mbox_flags
  import mbox_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NPROC-1:0][MAXCH-1:0] set_req,
  input  logic [NPROC-1:0][MAXCH-1:0] clr_req,
  output logic [NPROC-1:0][MAXCH-1:0] flag
);
  localparam logic [MAXCH-1:0] CHM = MAXCH'((32'd1 << NUM_CH) - 32'd1);

  for (genvar p = 0; p < NPROC; p++) begin : g_dir
    always_ff @(posedge clk) begin
      if (rst) flag[p] <= '0;
      // set wins over a clear from the peer in the same cycle
      else     flag[p] <= ((flag[p] & ~clr_req[NPROC-1-p]) | set_req[p]) & CHM;
    end
  end
endmodule

// File: rtl/mbox_irq.sv
// Registered receive / transmit interrupt for one processor.
module mbox_irq
  import mbox_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic [MAXCH-1:0] rx_mask,
  input  logic [MAXCH-1:0] tx_mask,
  input  logic [MAXCH-1:0] own_flag,
  input  logic [MAXCH-1:0] peer_flag,
  output logic             rx_irq,
  output logic             tx_irq
);
  localparam logic [MAXCH-1:0] CHM = MAXCH'((32'd1 << NUM_CH) - 32'd1);

  logic rx_any, tx_any;
  assign rx_any = |(peer_flag & ~rx_mask & CHM);
  assign tx_any = |(~own_flag & ~tx_mask & CHM);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b0;
    end else begin
      rx_irq <= rx_en & rx_any;
      tx_irq <= tx_en & tx_any;
    end
  end
endmodule

// File: rtl/mbox_flag_ctrl.sv
module mbox_flag_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [9:0]        addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [1:0]        rx_irq,
  output logic [1:0]        tx_irq
);
  logic [NPROC-1:0][MAXCH-1:0] set_req, clr_req, flag;
  logic [NPROC-1:0][MAXCH-1:0] rx_mask, tx_mask;
  logic [NPROC-1:0]            rx_en, tx_en;

  logic     bank_sel;
  logic     bank_range;
  reg_sel_e sel;
  assign bank_range = (addr[9:5] == 5'd0) && (addr[1:0] == 2'd0);
  assign bank_sel   = addr[4];
  assign sel        = reg_sel_e'(addr[3:2]);

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    logic hit;
    assign hit = wr_en && bank_range && (bank_sel == 1'(p));

    mbox_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk(clk), .rst(rst), .hit(hit), .sel(sel), .wdata(wdata),
      .rx_en(rx_en[p]), .tx_en(tx_en[p]),
      .rx_mask(rx_mask[p]), .tx_mask(tx_mask[p]),
      .set_req(set_req[p]), .clr_req(clr_req[p])
    );

    mbox_irq #(.NUM_CH(NUM_CH)) u_irq (
      .clk(clk), .rst(rst), .rx_en(rx_en[p]), .tx_en(tx_en[p]),
      .rx_mask(rx_mask[p]), .tx_mask(tx_mask[p]),
      .own_flag(flag[p]), .peer_flag(flag[NPROC-1-p]),
      .rx_irq(rx_irq[p]), .tx_irq(tx_irq[p])
    );
  end

  mbox_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst(rst), .set_req(set_req), .clr_req(clr_req), .flag(flag)
  );

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (bank_range) begin
      unique case (sel)
        SEL_CTRL:   rd_next = {15'd0, tx_en[bank_sel], 15'd0, rx_en[bank_sel]};
        SEL_MASK:   rd_next = {tx_mask[bank_sel], rx_mask[bank_sel]};
        SEL_SETCLR: rd_next = '0;
        SEL_STATUS: rd_next = {16'd0, flag[bank_sel]};
      endcase
    end else if (addr == CFG_ADDR) begin
      rd_next = 32'(NUM_CH) & 32'hFF;
    end else if (addr == VER_ADDR) begin
      rd_next = {24'd0, 4'(VER_MAJOR), 4'(VER_MINOR)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/mbox_flag_ctrl_chk.sv
module mbox_flag_ctrl_chk #(
  parameter int NUM_CH = 16
) (
  input logic        clk,
  input logic        rst,
  input logic [9:0]  addr,
  input logic        wr_en,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic [1:0]  rx_irq,
  input logic [1:0]  tx_irq,
  input logic [1:0][15:0] flag
);
  localparam logic [15:0] CHM = 16'((32'd1 << NUM_CH) - 32'd1);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (rx_irq == 2'b00 && tx_irq == 2'b00));

  // R5
  rx_needs_peer_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq[0] |-> $past(flag[1] != 16'd0));

  // R6
  tx_needs_free_chan_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq[1] |-> $past((~flag[1] & CHM) != 16'd0));

  // R3
  set_raises_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 10'h008 && wdata[16]) |=> flag[0][0]);

  // R4
  clear_drops_peer_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 10'h018 && wdata[0]) |=> !flag[0][0]);

  // R11
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr[9:5] != 5'd0 && addr[9:3] != 7'h7E) |=> rdata == 32'd0);
endmodule

bind mbox_flag_ctrl mbox_flag_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .rx_irq(rx_irq), .tx_irq(tx_irq), .flag(flag)
);

// File: tb/mbox_flag_ctrl_test.sv
module mbox_flag_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  rx_irq, tx_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mbox_flag_ctrl #(.NUM_CH(12), .VER_MAJOR(2), .VER_MINOR(3)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h000, 32'h0, 32'h0000_0000, 4'd1},  // R1 ctrl
    '{1'b0, 10'h004, 32'h0, 32'h0FFF_0FFF, 4'd1},  // R1 mask
    '{1'b0, 10'h014, 32'h0, 32'h0FFF_0FFF, 4'd2},  // R2 bank 1 mask
    '{1'b0, 10'h3F0, 32'h0, 32'h0000_000C, 4'd8},  // R8 channel count
    '{1'b0, 10'h3F4, 32'h0, 32'h0000_0023, 4'd8},  // R8 version
    '{1'b1, 10'h000, 32'hFFFF_FFFF, 32'h0, 4'd0},
    '{1'b0, 10'h000, 32'h0, 32'h0001_0001, 4'd2},  // R2 ctrl bits
    '{1'b0, 10'h010, 32'h0, 32'h0000_0000, 4'd2},  // R2 other bank apart
    '{1'b1, 10'h008, 32'h0005_0000, 32'h0, 4'd0},
    '{1'b0, 10'h00C, 32'h0, 32'h0000_0005, 4'd3},  // R3 own status
    '{1'b0, 10'h01C, 32'h0, 32'h0000_0000, 4'd3},  // R3 peer status
    '{1'b0, 10'h008, 32'h0, 32'h0000_0000, 4'd4},  // R4 reads zero
    '{1'b1, 10'h018, 32'h0000_0001, 32'h0, 4'd0},
    '{1'b0, 10'h00C, 32'h0, 32'h0000_0004, 4'd4},  // R4 peer clears ch0
    '{1'b1, 10'h018, 32'h0000_0000, 32'h0, 4'd0},
    '{1'b0, 10'h00C, 32'h0, 32'h0000_0004, 4'd4},  // R4 zeros no effect
    '{1'b1, 10'h008, 32'hF000_0000, 32'h0, 4'd0},
    '{1'b0, 10'h00C, 32'h0, 32'h0000_0004, 4'd9},  // R9 upper channels
    '{1'b1, 10'h004, 32'hFFFF_1234, 32'h0, 4'd0},
    '{1'b0, 10'h004, 32'h0, 32'h0FFF_0234, 4'd7},  // R7 / R9 mask
    '{1'b0, 10'h200, 32'h0, 32'h0000_0000, 4'd11}, // R11
    '{1'b0, 10'h3F8, 32'h0, 32'h0000_0000, 4'd11}, // R11
    '{1'b0, 10'h018, 32'h0, 32'h0000_0000, 4'd4}   // R4 bank 1 reads zero
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_read(input logic [9:0] a, output logic [31:0] d);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] rd;
    @(negedge clk);
    do_reset();
    check("R1 irqs", {28'd0, rx_irq, tx_irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) do_write(VECS[i].a, VECS[i].d);
      else begin
        do_read(VECS[i].a, rd);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
      end
    end

    // directed interrupt tests
    do_reset();
    check("R1 irqs after reset", {28'd0, rx_irq, tx_irq}, 32'd0);
    do_write(10'h008, 32'h0008_0000);            // p0 raises ch3
    @(negedge clk);
    check("R5 rx disabled", {31'd0, rx_irq[1]}, 32'd0);
    do_write(10'h010, 32'h0000_0001);            // p1 rx enable
    @(negedge clk);
    check("R5 rx masked", {31'd0, rx_irq[1]}, 32'd0);
    do_write(10'h014, 32'h0FFF_0FF7);            // unmask rx ch3 for p1
    check("R10 rx one cycle later", {31'd0, rx_irq[1]}, 32'd0);
    @(negedge clk);
    check("R5 rx asserted", {31'd0, rx_irq[1]}, 32'd1);
    check("R5 p0 rx quiet", {31'd0, rx_irq[0]}, 32'd0);
    do_write(10'h018, 32'h0000_0008);            // p1 drops ch3
    @(negedge clk);
    check("R5 rx after clear", {31'd0, rx_irq[1]}, 32'd0);

    do_write(10'h000, 32'h0001_0000);            // p0 tx enable
    do_write(10'h004, 32'h0FF7_0FFF);            // unmask tx ch3 for p0
    @(negedge clk);
    check("R6 tx free", {31'd0, tx_irq[0]}, 32'd1);
    do_write(10'h008, 32'h0008_0000);
    @(negedge clk);
    check("R6 tx occupied", {31'd0, tx_irq[0]}, 32'd0);
    do_write(10'h018, 32'h0000_0008);
    @(negedge clk);
    check("R6 tx freed again", {31'd0, tx_irq[0]}, 32'd1);

    do_write(10'h010, 32'h0001_0001);            // p1 tx enable, tx all masked
    @(negedge clk);
    @(negedge clk);
    check("R9 unimplemented not free", {31'd0, tx_irq[1]}, 32'd0);

    finish_run();
  end
endmodule